// File: doc/BRIEF.md
# Prescaled Up-Counter with Compare Flags and Write-Blocked Matching

The block is an up-counting timer that runs on the system clock. A tick enable either fires every cycle or is divided down by a power-of-two prescaler. On each tick the block compares the count present at that tick with each compare register. An equal value raises that channel's compare flag, and the flag serves as an interrupt request. When the count wraps from its maximum to zero, the overflow flag is raised.

Software uses a single write-strobe port. Through it, it loads the counter, loads the compare registers, and clears flags by writing ones. An interrupt controller clears a flag by pulsing the acknowledge bit for that flag. Any write to the counter suppresses the compare matches of the next tick, and this holds whether or not the timer is running. Software can therefore preload a compare register with the same value as the counter without raising a flag.

Top module: `cmp_timer`

## Requirements
- R1: While `rst_ni` is low, the counter, all compare registers, all flags, the prescaler and the block-match state are zero.
- R2: With `run_i` high, a tick occurs in each cycle in which the low `s` bits of the free-running prescaler are all ones. Here `s` is `div_sel_i`, saturated to `PRESC_W`, so one tick comes every 2^s cycles. The prescaler advances only while `run_i` is high. With `run_i` low, no tick occurs.
- R3: On a tick without a counter write, the counter increments by one. With no tick and no counter write, the counter holds its value.
- R4: A tick taken at the all-ones count moves the counter to zero and sets the overflow flag in the same edge.
- R5: On a tick without a counter write and without an active block, compare flag k sets when the count before the tick equals compare register k.
- R6: A write with `wr_sel_i` = 0 loads the counter from `wr_data_i`. It also arms the block, which suppresses every compare match of the next tick, and it overrides any tick in its own cycle. The block stays armed while no tick occurs, including while the timer is stopped.
- R7: The block does not affect overflow. A tick at the all-ones count still sets the overflow flag when the block is armed.
- R8: A write with `wr_sel_i` = 1 clears compare flag k where data bit k is one, and clears the overflow flag where data bit `N_CH` is one. Zero bits leave their flags unchanged.
- R9: A high `irq_ack_i[k]` clears compare flag k, and a high `irq_ack_i[N_CH]` clears the overflow flag. When a set and a clear meet in the same cycle, the set wins.
- R10: A write with `wr_sel_i` = 2+k loads compare register k from `wr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Timer enable |
| div_sel_i | input | DSEL_W | Prescale exponent; one tick every 2^value cycles |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | SEL_W | Target: 0 counter, 1 flag clear, 2+k compare k |
| wr_data_i | input | CNT_W | Write data |
| irq_ack_i | input | N_CH+1 | Per-flag acknowledge; top bit is overflow |
| cnt_o | output | CNT_W | Current count |
| cmp_flag_o | output | N_CH | Compare flags |
| ovf_flag_o | output | 1 | Overflow flag |

## Verification
The bench loads the counter with a compare value while the timer is stopped and then starts the timer. A design that drops the block early, or that does not arm it while stopped, would raise the flag on the first tick. A second corner loads the all-ones count while running. If the block were wrongly applied to overflow, the overflow flag would be missed. The bench also drives acknowledges and clears in the same cycle as matches, at random. A design with the wrong set-versus-clear priority would lose flags. Prescaler saturation and stopped periods are also exercised, and a wrong tick rate shows up at once as a count that drifts from the model.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned SEL_CNT  = 0;
  localparam int unsigned SEL_CLR  = 1;
  localparam int unsigned SEL_CMP0 = 2;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PRESC_W = 8,
  parameter int DSEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DSEL_W-1:0] div_sel_i,
  output logic              tick_o
);
  logic [PRESC_W-1:0] pre_q;
  logic [PRESC_W-1:0] mask;
  logic [DSEL_W-1:0]  sel_sat;

  always_comb begin
    sel_sat = (int'(div_sel_i) > PRESC_W) ? DSEL_W'(PRESC_W) : div_sel_i;
    for (int i = 0; i < PRESC_W; i++) mask[i] = (i < int'(sel_sat));
  end

  assign tick_o = run_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (run_i) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             blk_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             blk_q;

  assign wrap_o = tick_i && !load_i && (cnt_q == '1);
  assign cnt_o  = cnt_q;
  assign blk_o  = blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      blk_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
      blk_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ct_channel.sv
module ct_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             blk_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_cmp_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             flag_q;
  logic             hit;

  // match judged on the count held when the tick arrives
  assign hit    = tick_i && !load_i && !blk_i && (cnt_i == cmp_q);
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (wr_cmp_i) cmp_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter  int CNT_W   = 8,
  parameter  int N_CH    = 2,
  parameter  int PRESC_W = 8,
  localparam int DSEL_W  = $clog2(PRESC_W + 1),
  localparam int SEL_W   = $clog2(N_CH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DSEL_W-1:0] div_sel_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [N_CH:0]     irq_ack_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [N_CH-1:0]   cmp_flag_o,
  output logic              ovf_flag_o
);
  logic tick, ld_cnt, blk, wrap, wr_clr, ovf_q;

  assign ld_cnt = wr_en_i && (int'(wr_sel_i) == SEL_CNT);
  assign wr_clr = wr_en_i && (int'(wr_sel_i) == SEL_CLR);

  ct_prescaler #(.PRESC_W(PRESC_W), .DSEL_W(DSEL_W)) i_presc (
    .clk_i, .rst_ni, .run_i, .div_sel_i, .tick_o(tick)
  );

  ct_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(ld_cnt), .load_val_i(wr_data_i),
    .cnt_o, .blk_o(blk), .wrap_o(wrap)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    ct_channel #(.CNT_W(CNT_W)) i_ch (
      .clk_i, .rst_ni, .tick_i(tick), .blk_i(blk), .load_i(ld_cnt),
      .cnt_i(cnt_o),
      .wr_cmp_i(wr_en_i && (int'(wr_sel_i) == SEL_CMP0 + k)),
      .wr_data_i,
      .clr_i((wr_clr && wr_data_i[k]) || irq_ack_i[k]),
      .flag_o(cmp_flag_o[k])
    );
  end

  // overflow ignores the block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_q <= 1'b0;
    else if (wrap)  ovf_q <= 1'b1;
    else if ((wr_clr && wr_data_i[N_CH]) || irq_ack_i[N_CH]) ovf_q <= 1'b0;
  end
  assign ovf_flag_o = ovf_q;
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int CNT_W = 8,
  parameter int N_CH  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             tick,
  input logic             blk,
  input logic             ld_cnt,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [N_CH-1:0]  cmp_flag_o,
  input logic             ovf_flag_o
);
  p_no_tick_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick);

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ld_cnt) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !ld_cnt) |=> $stable(cnt_o));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ld_cnt && cnt_o == '1) |=> (cnt_o == '0 && ovf_flag_o));

  p_flag_needs_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> ((cmp_flag_o & ~$past(cmp_flag_o)) == '0));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_cnt |=> (cnt_o == $past(wr_data_i) && blk));

  p_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk && tick) |=> ((cmp_flag_o & ~$past(cmp_flag_o)) == '0));
endmodule

bind cmp_timer ct_checker #(.CNT_W(CNT_W), .N_CH(N_CH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick(tick), .blk(blk),
  .ld_cnt(ld_cnt), .wr_data_i(wr_data_i), .cnt_o(cnt_o),
  .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o)
);

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int N_CH = 2;
  localparam int PRESC_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0, run_i = 1'b0, wr_en_i = 1'b0;
  logic [3:0] div_sel_i = '0;
  logic [1:0] wr_sel_i = '0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic [N_CH:0] irq_ack_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic [N_CH-1:0] cmp_flag_o;
  logic ovf_flag_o;

  int n_chk = 0, n_bad = 0;

  // reference state
  int m_cnt, m_pre, m_cmp[N_CH];
  bit m_flag[N_CH], m_ovf, m_blk;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_timer #(.CNT_W(CNT_W), .N_CH(N_CH), .PRESC_W(PRESC_W)) i_cmp_timer (
    .clk_i(clk), .rst_ni, .run_i, .div_sel_i, .wr_en_i, .wr_sel_i,
    .wr_data_i, .irq_ack_i, .cnt_o, .cmp_flag_o, .ovf_flag_o
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_pre = 0; m_ovf = 0; m_blk = 0;
    for (int k = 0; k < N_CH; k++) begin m_cmp[k] = 0; m_flag[k] = 0; end
  endtask

  task automatic model_edge();
    int s, msk, clr;
    bit tk, ld;
    s   = (int'(div_sel_i) > PRESC_W) ? PRESC_W : int'(div_sel_i);
    msk = (1 << s) - 1;
    tk  = run_i && ((m_pre & msk) == msk);
    if (run_i) m_pre = (m_pre + 1) % (1 << PRESC_W);
    ld  = wr_en_i && wr_sel_i == 0;
    clr = (wr_en_i && wr_sel_i == 1) ? int'(wr_data_i) : 0;
    for (int k = 0; k < N_CH; k++) begin
      if (tk && !ld && !m_blk && m_cnt == m_cmp[k]) m_flag[k] = 1;
      else if (clr[k] || irq_ack_i[k]) m_flag[k] = 0;
    end
    if (tk && !ld && m_cnt == (1 << CNT_W) - 1) m_ovf = 1;
    else if (clr[N_CH] || irq_ack_i[N_CH]) m_ovf = 0;
    for (int k = 0; k < N_CH; k++)
      if (wr_en_i && int'(wr_sel_i) == 2 + k) m_cmp[k] = int'(wr_data_i);
    if (ld) begin m_cnt = int'(wr_data_i); m_blk = 1; end
    else if (tk) begin m_cnt = (m_cnt + 1) % (1 << CNT_W); m_blk = 0; end
  endtask

  task automatic check_all(string tag);
    chk({tag, " R3 count"}, int'(cnt_o), m_cnt);
    for (int k = 0; k < N_CH; k++) chk({tag, " R5 cmp flag"}, int'(cmp_flag_o[k]), int'(m_flag[k]));
    chk({tag, " R4 ovf flag"}, int'(ovf_flag_o), int'(m_ovf));
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all("cycle");
      wr_en_i = 1'b0;
      irq_ack_i = '0;
    end
  endtask

  task automatic wr(int sel, int data);
    wr_en_i = 1'b1; wr_sel_i = 2'(sel); wr_data_i = CNT_W'(data);
    step();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_ni = 1'b1;
    // R10 compare loads, R5 matches
    wr(2, 3); wr(3, 200);
    run_i = 1'b1; div_sel_i = 0;
    step(10);
    check_all("R10");
    chk("R5 flag0 after pass 3", int'(cmp_flag_o[0]), 1);
    // R9 acknowledge
    irq_ack_i = 3'b001; step();
    chk("R9 ack clears", int'(cmp_flag_o[0]), 0);
    // R8 zero bits no effect, ones clear
    step(250);
    wr(1, 0);
    check_all("R8 zero write");
    chk("R8 ovf kept", int'(ovf_flag_o), 1);
    wr(1, 7);
    chk("R8 ovf cleared", int'(ovf_flag_o), 0);
    check_all("R8");
    step(260);
    check_all("R4");
    // R6 blocked while stopped
    run_i = 1'b0; wr(1, 7);
    wr(0, 3);
    step(5);
    check_all("R6 stopped");
    run_i = 1'b1; step(3);
    chk("R6 blocked match", int'(cmp_flag_o[0]), 0);
    // R7 overflow not blocked
    wr(1, 7);
    wr(0, 255);
    step();
    chk("R7 ovf despite block", int'(ovf_flag_o), 1);
    // R2 prescaler
    div_sel_i = 2; step(40); check_all("R2 div4");
    div_sel_i = 15; step(600); check_all("R2 saturate");
    run_i = 1'b0; step(10); check_all("R2 stopped");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      run_i = ($urandom % 8) != 0;
      div_sel_i = 4'($urandom % 3);
      irq_ack_i = ($urandom % 4 == 0) ? 3'($urandom) : 3'b0;
      if ($urandom % 16 == 0) begin
        wr_en_i = 1'b1; wr_sel_i = 2'($urandom); wr_data_i = CNT_W'($urandom % 8);
      end
      step();
    end
    check_all("R9 random");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule